// File: doc/BRIEF.md
# FSK Receive Data Serial Interface

This block sits behind an FSK demodulator that delivers a recovered 1200-baud asynchronous bit stream and a carrier qualifier. It frames each character (one start bit, eight data bits, one stop bit) and hands the result to a microcontroller over three wires. A static mode input chooses between two presentations. In bit-stream mode the block drives the qualified raw data and its own data clock, whose rising edge lands in the middle of each bit cell. In byte-buffer mode it removes the start and stop bits and holds one byte. It flags the byte with an active-low ready strobe, and the host shifts the byte out with its own clock.

Bit timing comes from a prescaled system clock. The default cell length of 2976 cycles matches a 3.579545 MHz crystal divided down to about 1202.8 Hz. A stop bit found at space is reported as a framing error. A byte that lands before the previous one has been read completely replaces it and raises an overrun flag. An active-low power-down input clears all state and parks the outputs.

Top module: `fsk_rx_if`

## Requirements
- R1: After reset, and in every cycle after a cycle with `pwrDnN` low, the outputs are idle: `readyN`=1, `clkOut`=0, `frameErr`=0, `overrun`=0 and `carrierOut`=0. `dataOut`=1 while reset or power-down is held.
- R2: In bit-stream mode (`byteMode`=0), `dataOut` equals `rxBit` while `carrierIn`=1 and is 1 (mark) while `carrierIn`=0. `carrierOut` follows `carrierIn` one cycle later.
- R3: A start bit is taken at the first clock edge E0 where the qualified data is 0. In bit-stream mode, `clkOut` rises after edge E0+HALF+n*BIT_CYC for cells n=0..9 and stays high for HALF cycles, where HALF=BIT_CYC/2. A start pulse that is back at 1 by mid-cell gives no clock pulse and no character.
- R4: In byte-buffer mode, `readyN` falls after edge E0+HALF+9*BIT_CYC, which is the stop-bit sample. From then on, `dataOut` shows data bit 0, the first bit received, which is the LSB.
- R5: Each rising edge of `hostClk` takes effect two clock edges after the first clock edge that sees it high, and moves `dataOut` to the next bit, LSB first. After the eighth edge, `readyN`=1 and `dataOut`=1.
- R6: If the byte is not fully read, `readyN` returns to 1 exactly 9*BIT_CYC cycles after it fell. The unread bits stay readable with further `hostClk` edges.
- R7: `frameErr` is set to 1 when the stop bit of the latest byte was sampled as 0, and to 0 when it was 1. It is updated with every new byte.
- R8: A byte loaded while the previous byte still has unread bits sets `overrun`=1. A byte loaded with no unread bits sets `overrun`=0. An eighth host edge that takes effect in the same cycle as a load completes the old byte, so `overrun`=0 and the new byte starts at bit 0. A host edge after the load applies to the new byte.
- R9: In byte-buffer mode `clkOut` stays 0. In bit-stream mode `readyN` stays 1 and `hostClk` has no effect.
- R10: A power-down pulse during a character discards that character: no byte is presented from it, and the next full character is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrDnN | input | 1 | Power-down, active low; clears state and idles outputs |
| byteMode | input | 1 | Static mode select: 1 byte-buffer, 0 bit-stream |
| rxBit | input | 1 | Recovered bit from the demodulator (1 = mark) |
| carrierIn | input | 1 | Carrier present qualifier from the demodulator |
| hostClk | input | 1 | Host shift clock (byte-buffer mode), asynchronous |
| dataOut | output | 1 | Serial data to the host |
| clkOut | output | 1 | Generated data clock (bit-stream mode) |
| readyN | output | 1 | Byte ready strobe, active low |
| frameErr | output | 1 | Stop bit of the latest byte was a space |
| overrun | output | 1 | Latest byte replaced an unread byte |
| carrierOut | output | 1 | Registered carrier status |

## Verification
The most delicate case is a new byte loading in the very cycle that the host's eighth shift edge takes effect on the old byte. The bench provokes it by sweeping the last host edge over five consecutive cycles around the stop-bit sample of a following character. Each run is judged by `overrun` and by which bit of the new byte is on `dataOut`. The expected values are derived from the synchroniser delay and the load cycle stated in R4, R5 and R8: the old byte counts as read up to and including the load cycle, and a later edge belongs to the new byte.

// File: rtl/fskrx_pkg.sv
package fskrx_pkg;
  // strobes issued by the frame sequencer to the datapath and host side
  typedef struct packed {
    logic sampleAny;  // a valid mid-cell sample of any cell of a character
    logic shiftData;  // mid-cell sample of a data cell
    logic frameEnd;   // mid-cell sample of the stop cell
  } rxStb_t;
endpackage

// File: rtl/fskrx_ctrl.sv
module fskrx_ctrl
  import fskrx_pkg::*;
#(
  parameter int BIT_CYC  = 2976,
  parameter int HALF_CYC = 1488
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   pwrDnN,
  input  logic   qData,
  output rxStb_t stb
);
  localparam int CW = $clog2(BIT_CYC);
  localparam logic [CW-1:0] MID  = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] LAST = CW'(BIT_CYC - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [3:0]    bitIdx;
  logic          atMid;
  logic          falseStart;

  always_comb begin
    atMid          = active && (cnt == MID);
    falseStart     = atMid && (bitIdx == 4'd0) && qData;
    stb.sampleAny  = atMid && !falseStart;
    stb.shiftData  = atMid && (bitIdx >= 4'd1) && (bitIdx <= 4'd8);
    stb.frameEnd   = atMid && (bitIdx == 4'd9);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (!pwrDnN) begin
      active <= 1'b0;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (!active) begin
      if (!qData) begin
        active <= 1'b1;
        cnt    <= '0;
        bitIdx <= '0;
      end
    end else if (falseStart || stb.frameEnd) begin
      active <= 1'b0;
    end else if (cnt == LAST) begin
      cnt    <= '0;
      bitIdx <= bitIdx + 4'd1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fskrx_dp.sv
module fskrx_dp
  import fskrx_pkg::*;
#(
  parameter int HALF_CYC = 1488
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDnN,
  input  logic       rxBit,
  input  logic       carrierIn,
  input  rxStb_t     stb,
  output logic       qData,
  output logic [7:0] shByte,
  output logic       stopErr,
  output logic       clkPulse,
  output logic       carrierQ
);
  localparam int PW = $clog2(HALF_CYC + 1);

  logic [7:0]    shReg;
  logic [PW-1:0] pulCnt;

  assign qData    = carrierIn ? rxBit : 1'b1;
  assign shByte   = shReg;
  assign stopErr  = stb.frameEnd && !qData;
  assign clkPulse = (pulCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      pulCnt   <= '0;
      carrierQ <= 1'b0;
    end else if (!pwrDnN) begin
      shReg    <= '0;
      pulCnt   <= '0;
      carrierQ <= 1'b0;
    end else begin
      carrierQ <= carrierIn;
      if (stb.shiftData) shReg <= {qData, shReg[7:1]};
      if (stb.sampleAny)      pulCnt <= PW'(HALF_CYC);
      else if (pulCnt != '0)  pulCnt <= pulCnt - 1'b1;
    end
  end
endmodule

// File: rtl/fskrx_hostif.sv
module fskrx_hostif #(
  parameter int TMO_CYC = 26784
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDnN,
  input  logic       byteMode,
  input  logic       hostClk,
  input  logic       frameEnd,
  input  logic [7:0] newByte,
  input  logic       stopErr,
  output logic       readyN,
  output logic       bitOut,
  output logic       frameErr,
  output logic       overrun
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [2:0]    syncQ;
  logic [7:0]    holdReg;
  logic [2:0]    idx;
  logic          unread;
  logic [TW-1:0] tmoCnt;
  logic          rise;
  logic          load;
  logic          lastEdge;

  assign rise     = syncQ[1] & ~syncQ[2];
  assign load     = frameEnd & byteMode;
  assign lastEdge = rise & unread & (idx == 3'd7);
  assign bitOut   = unread ? holdReg[idx] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      holdReg  <= '0;
      idx      <= '0;
      unread   <= 1'b0;
      readyN   <= 1'b1;
      tmoCnt   <= '0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else if (!pwrDnN) begin
      syncQ    <= '0;
      holdReg  <= '0;
      idx      <= '0;
      unread   <= 1'b0;
      readyN   <= 1'b1;
      tmoCnt   <= '0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      syncQ <= {syncQ[1:0], hostClk};
      if (load) begin
        holdReg  <= newByte;
        idx      <= '0;
        unread   <= 1'b1;
        readyN   <= 1'b0;
        tmoCnt   <= TW'(TMO_CYC);
        frameErr <= stopErr;
        overrun  <= unread & ~lastEdge;
      end else begin
        if (rise && unread) begin
          if (idx == 3'd7) begin
            unread <= 1'b0;
            idx    <= '0;
          end else begin
            idx <= idx + 3'd1;
          end
        end
        if (!readyN) begin
          if (lastEdge || tmoCnt == TW'(1)) readyN <= 1'b1;
          else                              tmoCnt <= tmoCnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fsk_rx_if.sv
module fsk_rx_if #(
  parameter int BIT_CYC = 2976
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrDnN,
  input  logic byteMode,
  input  logic rxBit,
  input  logic carrierIn,
  input  logic hostClk,
  output logic dataOut,
  output logic clkOut,
  output logic readyN,
  output logic frameErr,
  output logic overrun,
  output logic carrierOut
);
  import fskrx_pkg::*;

  localparam int HALF_CYC = BIT_CYC / 2;
  localparam int TMO_CYC  = 9 * BIT_CYC;

  rxStb_t     stb;
  logic       qData;
  logic [7:0] shByte;
  logic       stopErr;
  logic       clkPulse;
  logic       bitOut;
  logic       readyInt;

  fskrx_ctrl #(.BIT_CYC(BIT_CYC), .HALF_CYC(HALF_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .qData(qData), .stb(stb)
  );

  fskrx_dp #(.HALF_CYC(HALF_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .rxBit(rxBit),
    .carrierIn(carrierIn), .stb(stb), .qData(qData), .shByte(shByte),
    .stopErr(stopErr), .clkPulse(clkPulse), .carrierQ(carrierOut)
  );

  fskrx_hostif #(.TMO_CYC(TMO_CYC)) u_host (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .byteMode(byteMode),
    .hostClk(hostClk), .frameEnd(stb.frameEnd), .newByte(shByte),
    .stopErr(stopErr), .readyN(readyInt), .bitOut(bitOut),
    .frameErr(frameErr), .overrun(overrun)
  );

  assign dataOut = (!pwrDnN || !rstN) ? 1'b1 : (byteMode ? bitOut : qData);
  assign clkOut  = pwrDnN && !byteMode && clkPulse;
  assign readyN  = readyInt || !pwrDnN;
endmodule

// File: rtl/fskrx_chk.sv
module fskrx_chk (
  input logic clk,
  input logic rstN,
  input logic pwrDnN,
  input logic byteMode,
  input logic readyN,
  input logic clkOut,
  input logic frameErr,
  input logic overrun
);
  // R1: a power-down cycle leaves the registered outputs idle
  p_pd_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDnN |=> (readyN && !clkOut && !frameErr && !overrun));

  // R9: the ready strobe only ever falls when the byte-buffer mode was selected
  p_ready_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyN) |-> $past(byteMode));

  // R8: overrun can only appear together with a freshly loaded byte
  p_ovr_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> !readyN);

  // R3: a generated clock pulse lasts more than one cycle
  p_clk_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkOut) |=> (clkOut || !pwrDnN || byteMode));
endmodule

bind fsk_rx_if fskrx_chk u_chk (
  .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .byteMode(byteMode),
  .readyN(readyN), .clkOut(clkOut), .frameErr(frameErr), .overrun(overrun)
);

// File: tb/fsk_rx_if_tb.sv
module fsk_rx_if_tb;
  localparam int BC  = 20;
  localparam int HC  = BC / 2;
  localparam int TMO = 9 * BC;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, pwrDnN, byteMode, rxBit, carrierIn, hostClk;
  logic dataOut, clkOut, readyN, frameErr, overrun, carrierOut;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  fsk_rx_if #(.BIT_CYC(BC)) u_dut (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .byteMode(byteMode),
    .rxBit(rxBit), .carrierIn(carrierIn), .hostClk(hostClk),
    .dataOut(dataOut), .clkOut(clkOut), .readyN(readyN),
    .frameErr(frameErr), .overrun(overrun), .carrierOut(carrierOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected cell value: start, eight data bits LSB first, stop
  function automatic logic cellVal(input logic [7:0] b, input logic stopV, input int n);
    if (n == 0) return 1'b0;
    if (n == 9) return stopV;
    return b[n-1];
  endfunction

  task automatic sendFrame(input logic [7:0] b, input logic stopV, input bit doChk);
    for (int n = 0; n < 10; n++) begin
      rxBit = cellVal(b, stopV, n);
      tick(HC);
      if (doChk) begin
        if (!byteMode) begin
          chk("R3 clock low before mid-cell", clkOut, 0);
          chk("R2 data follows rx", dataOut, cellVal(b, stopV, n));
        end else begin
          chk("R9 no clock in byte mode", clkOut, 0);
          if (n == 9) chk("R4 ready high before stop sample", readyN, 1);
        end
      end
      tick(1);
      if (doChk) begin
        if (!byteMode) begin
          chk("R3 clock rises at mid-cell", clkOut, 1);
          chk("R9 ready idle in bit mode", readyN, 1);
        end else if (n == 9) begin
          chk("R4 ready falls at stop sample", readyN, 0);
          chk("R4 first bit is LSB", dataOut, b[0]);
        end
      end
      tick(BC - HC - 1);
    end
    rxBit = 1'b1;
  endtask

  task automatic hostPulse();
    hostClk = 1'b1; tick(4);
    hostClk = 1'b0; tick(4);
  endtask

  task automatic readByte(output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      got[i] = dataOut;
      hostPulse();
    end
    chk("R5 ready high after eighth edge", readyN, 1);
    chk("R5 data mark after read", dataOut, 1);
  endtask

  task automatic pdPulse();
    pwrDnN = 1'b0; tick(2);
    chk("R1 pd data mark", dataOut, 1);
    pwrDnN = 1'b1; tick(1);
    chk("R1 pd ready idle", readyN, 1);
    chk("R1 pd overrun clear", overrun, 0);
    chk("R1 pd framing clear", frameErr, 0);
  endtask

  initial begin
    logic [7:0] val, got;
    rstN = 1'b0; pwrDnN = 1'b1; byteMode = 1'b0; rxBit = 1'b1;
    carrierIn = 1'b0; hostClk = 1'b0;
    tick(3);
    chk("R1 reset readyN", readyN, 1);
    chk("R1 reset clkOut", clkOut, 0);
    chk("R1 reset dataOut", dataOut, 1);
    chk("R1 reset frameErr", frameErr, 0);
    chk("R1 reset overrun", overrun, 0);
    chk("R1 reset carrierOut", carrierOut, 0);
    rstN = 1'b1; tick(2);

    // R2: no carrier, data forced to mark, no clock
    rxBit = 1'b0; tick(3);
    chk("R2 mark without carrier", dataOut, 1);
    chk("R2 carrier status low", carrierOut, 0);
    tick(2 * BC);
    chk("R3 no clock without carrier", clkOut, 0);
    rxBit = 1'b1;
    carrierIn = 1'b1; tick(2);
    chk("R2 carrier status follows", carrierOut, 1);

    // R3: short start glitch gives nothing
    rxBit = 1'b0; tick(3); rxBit = 1'b1;
    tick(HC + 2);
    chk("R3 glitch gives no clock", clkOut, 0);
    tick(BC);

    // bit-stream mode, random characters
    for (int k = 0; k < 4; k++) begin
      val = 8'($urandom);
      sendFrame(val, 1'b1, 1'b1);
      tick(5);
    end
    for (int k = 0; k < 8; k++) hostPulse();
    chk("R9 host clock ignored in bit mode", readyN, 1);
    chk("R9 no overrun in bit mode", overrun, 0);

    // byte-buffer mode, random characters
    byteMode = 1'b1; tick(2);
    for (int k = 0; k < 6; k++) begin
      val = 8'($urandom);
      sendFrame(val, 1'b1, 1'b1);
      chk("R8 no overrun after clean read", overrun, 0);
      chk("R7 good stop bit", frameErr, 0);
      readByte(got);
      chk("R5 byte read back", got, val);
      tick(5);
    end

    // R7 framing error then recovery
    sendFrame(8'h5A, 1'b0, 1'b1);
    chk("R7 framing error flagged", frameErr, 1);
    readByte(got);
    chk("R7 byte with bad stop", got, 8'h5A);
    tick(5);
    sendFrame(8'hA5, 1'b1, 1'b1);
    chk("R7 framing error cleared", frameErr, 0);
    readByte(got);
    chk("R7 next byte intact", got, 8'hA5);
    tick(5);

    // R6 timeout of the ready strobe
    sendFrame(8'h3C, 1'b1, 1'b1);
    tick(HC + TMO - BC);
    chk("R6 ready still low before timeout", readyN, 0);
    tick(1);
    chk("R6 ready released at timeout", readyN, 1);
    readByte(got);
    chk("R6 byte readable after timeout", got, 8'h3C);
    tick(5);

    // R8 collision of the eighth host edge with a new load
    for (int d = -2; d <= 2; d++) begin
      pdPulse();
      tick(3);
      sendFrame(8'h0F, 1'b1, 1'b1);
      tick(5);
      for (int i = 0; i < 7; i++) hostPulse();
      fork
        sendFrame(8'h66, 1'b1, 1'b0);
        begin
          tick(HC + 9 * BC - 2 + d);
          hostClk = 1'b1; tick(4);
          hostClk = 1'b0;
        end
      join
      chk("R8 ready low after collision", readyN, 0);
      chk("R8 overrun at collision", overrun, (d > 0) ? 1 : 0);
      chk("R8 data bit after collision", dataOut, (d > 0) ? 1 : 0);
      tick(5);
    end

    // R10 power-down in the middle of a character
    pdPulse();
    tick(3);
    fork
      sendFrame(8'hFF, 1'b1, 1'b0);
      begin
        tick(5 * BC);
        pwrDnN = 1'b0; tick(3);
        pwrDnN = 1'b1;
      end
    join
    tick(20);
    chk("R10 aborted character not presented", readyN, 1);
    chk("R10 no framing error", frameErr, 0);
    sendFrame(8'h81, 1'b1, 1'b1);
    readByte(got);
    chk("R10 next character received", got, 8'h81);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule